// File: doc/BRIEF.md
# Oscillator Trim Search Controller

This block tunes a local oscillator through its trim code. A line driven by a remote transmitter carries low and high periods of equal, known length. The block counts local clock cycles across each low period and compares the count with a target count. The high period that follows gives the oscillator time to settle, and the block applies one correction to the trim code at the rising edge that ends the low period. A single-clock strobe marks each falling and each rising line edge; edge qualification and the oscillator itself are outside the block.

The correction follows a binary search. The trim begins at a chosen code and the first step is a quarter of the trim range, and the step halves after every correction. The trim code is only pseudo-monotone: one unit up can lower the frequency slightly, but two units up always raise it. An optional neighbour phase therefore probes two more unit steps past the binary result and keeps whichever of the three measured codes came closest to the target. A retry request in repeated-frame mode lets a failed attempt continue from the trim it reached.

Top module: `osc_trim_search`

## Requirements
- R1: After reset, `trim_o` is the mid-range code 2^(TRIM_W-1) (128 by default), and `busy_o`, `done_o` and `done_err_o` are zero.
- R2: A `start_i` pulse loads `trim_o` from `default_trim_i` and raises `busy_o` in the next cycle. `start_i` overrides every other input and restarts a run already in progress.
- R3: A measured count is the number of clock cycles from an accepted fall strobe to the accepting rise strobe. The count is 9 bits wide (an 8-bit counter plus a sticky overflow bit) and holds at 511. A rise strobe that arrives before any fall strobe is ignored. A fall strobe that arrives while a low period is already being timed is ignored.
- R4: In the binary phase, the first step is 2^INIT_STEP_LOG2 (64 by default). If the count is above target+tolerance, the trim drops by the step. If the count is below target-tolerance, the trim rises by the step. After each correction the step halves.
- R5: With the neighbour phase disabled (`nbr_en_i`=0), a count within the tolerance ends the run. The trim stays unchanged and `done_err_o` = count - target.
- R6: With the neighbour phase disabled, the run ends once the step halves to zero. The trim keeps its last corrected value and `done_err_o` holds the error of the final measurement.
- R7: With the neighbour phase enabled, the tolerance is ignored. Only an exact match ends the binary phase early.
- R8: In the neighbour phase there are two more measurements. Each one moves the trim by one unit in the direction of the last binary correction. The run then loads the code with the smallest absolute error among three: the last binary-measured code and the two neighbour codes. On a tie the earlier code wins. `done_err_o` is that code's error.
- R9: The trim saturates at 0 and at 2^TRIM_W-1 instead of wrapping.
- R10: A start with `rep_mode_i`=1 and `retry_i`=1 keeps the current trim instead of loading the default.
- R11: A run's trim update and `done_o` appear in the cycle after the rise strobe that caused them. `done_o` lasts exactly one cycle, and `busy_o` is low in that same cycle.
- R12: When the block is idle, edge strobes change neither `trim_o` nor `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the tuned oscillator |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a calibration run |
| rep_mode_i | input | 1 | Repeated-frame mode: retries keep the trim |
| retry_i | input | 1 | This start retries a failed attempt |
| nbr_en_i | input | 1 | Enable the neighbour phase |
| fall_i | input | 1 | Falling-edge strobe of the line |
| rise_i | input | 1 | Rising-edge strobe of the line |
| target_i | input | 9 | Wanted count per low period |
| tol_i | input | 9 | Accepted count deviation (binary-only mode) |
| default_trim_i | input | 8 | Trim code loaded at a normal start |
| trim_o | output | 8 | Trim code driving the oscillator |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the trim is final |
| done_err_o | output | 10 | Signed final count minus target |

## Verification
The trim and `done_o` are both registered at the clock edge where the rise strobe is sampled, so they are due one cycle after that strobe. `busy_o` and the loaded trim are due one cycle after `start_i`. The bench drives the strobes on falling clock edges and places each rise strobe so that the edge sampling it falls exactly the intended number of cycles after the fall strobe. It samples every result on the falling edge that follows, and checks one edge later that `done_o` has dropped again. Its line model derives each low-period length from the current `trim_o`, so the expected final codes, errors and measurement counts are worked out by hand from the requirements.

// File: rtl/trim_pkg.sv
// Shared types for the oscillator trim search controller.
// Assumes nothing beyond a synthesizable SystemVerilog flow.
package trim_pkg;

    // Line phase the controller is waiting for.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_FALL = 2'd1,
        ST_WAIT_RISE = 2'd2
    } trim_state_e;

endpackage

// File: rtl/trim_cycle_counter.sv
// Low-period cycle counter: a CNT_W-bit counter plus a sticky overflow bit
// forming a CNT_W+1 bit count that holds at all ones.
// Assumes clr_i is a one-cycle pulse on the accepted fall strobe; the count
// seen in the cycle of a later rise strobe equals the strobe distance.
module trim_cycle_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W:0]   meas_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    // Restart at one on a fall, otherwise count up until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q <= CNT_W'(1);
            ovf_q <= 1'b0;
        end else if (!(ovf_q && (&cnt_q))) begin
            {ovf_q, cnt_q} <= {ovf_q, cnt_q} + 1'b1;
        end
    end

    assign meas_o = {ovf_q, cnt_q};
endmodule

// File: rtl/trim_err_calc.sv
// Count comparator: signed error, absolute error and the too-high /
// too-low decisions against target and tolerance.
// Assumes unsigned inputs; exact_i forces a zero tolerance.
module trim_err_calc #(
    parameter int MEAS_W = 9
) (
    input  logic                     exact_i,
    input  logic [MEAS_W-1:0]        meas_i,
    input  logic [MEAS_W-1:0]        target_i,
    input  logic [MEAS_W-1:0]        tol_i,
    output logic signed [MEAS_W:0]   err_o,
    output logic [MEAS_W-1:0]        abs_o,
    output logic                     too_high_o,
    output logic                     too_low_o
);
    logic [MEAS_W:0] m_e, t_e, tol_e;

    // Widen by one bit so sums and differences cannot wrap.
    always_comb begin
        m_e   = {1'b0, meas_i};
        t_e   = {1'b0, target_i};
        tol_e = exact_i ? '0 : {1'b0, tol_i};
        err_o      = signed'(m_e - t_e);
        abs_o      = (meas_i >= target_i) ? (meas_i - target_i) : (target_i - meas_i);
        too_high_o = m_e > (t_e + tol_e);
        too_low_o  = (m_e + tol_e) < t_e;
    end
endmodule

// File: rtl/trim_best_track.sv
// Keeps the trim code with the smallest absolute error seen so far and
// offers the winner between that record and the current candidate.
// Assumes load_i and upd_i are never high together; ties keep the record.
module trim_best_track #(
    parameter int TRIM_W = 8,
    parameter int MEAS_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     upd_i,
    input  logic [TRIM_W-1:0]        trim_i,
    input  logic signed [MEAS_W:0]   err_i,
    input  logic [MEAS_W-1:0]        abs_i,
    output logic [TRIM_W-1:0]        win_trim_o,
    output logic signed [MEAS_W:0]   win_err_o
);
    logic [TRIM_W-1:0]      best_trim_q;
    logic signed [MEAS_W:0] best_err_q;
    logic [MEAS_W-1:0]      best_abs_q;
    logic                   better;

    // Strictly smaller error replaces the record.
    always_comb begin
        better     = abs_i < best_abs_q;
        win_trim_o = better ? trim_i : best_trim_q;
        win_err_o  = better ? err_i  : best_err_q;
    end

    // Record update on a seed or on a better candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_trim_q <= '0;
            best_err_q  <= '0;
            best_abs_q  <= '1;
        end else if (load_i || (upd_i && better)) begin
            best_trim_q <= trim_i;
            best_err_q  <= err_i;
            best_abs_q  <= abs_i;
        end
    end
endmodule

// File: rtl/osc_trim_search.sv
// Oscillator trim search controller. It times each low period of the line,
// steps the trim with a halving binary search at each rising edge, and can
// finish with a two-step neighbour probe that keeps the best of three codes.
// Assumes target, tolerance and mode inputs are held stable during a run and
// that fall/rise strobes are single-cycle and already qualified.
module osc_trim_search
    import trim_pkg::*;
#(
    parameter int TRIM_W         = 8,
    parameter int CNT_W          = 8,
    parameter int INIT_STEP_LOG2 = TRIM_W - 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    rep_mode_i,
    input  logic                    retry_i,
    input  logic                    nbr_en_i,
    input  logic                    fall_i,
    input  logic                    rise_i,
    input  logic [CNT_W:0]          target_i,
    input  logic [CNT_W:0]          tol_i,
    input  logic [TRIM_W-1:0]       default_trim_i,
    output logic [TRIM_W-1:0]       trim_o,
    output logic                    busy_o,
    output logic                    done_o,
    output logic signed [CNT_W+1:0] done_err_o
);
    localparam int MEAS_W = CNT_W + 1;
    localparam logic [TRIM_W-1:0] TRIM_MID  = TRIM_W'(1) << (TRIM_W - 1);
    localparam logic [TRIM_W-1:0] STEP_INIT = TRIM_W'(1) << INIT_STEP_LOG2;

    trim_state_e            state_q;
    logic [TRIM_W-1:0]      trim_q, step_q, step_half;
    logic                   dir_up_q, nbr_q, nidx_q, done_q;
    logic signed [MEAS_W:0] err_q;

    logic [MEAS_W-1:0]      meas;
    logic signed [MEAS_W:0] err;
    logic [MEAS_W-1:0]      err_abs;
    logic                   too_high, too_low;
    logic                   fall_ok, rise_ok, bin_hit, bin_last;
    logic                   best_load, best_upd;
    logic [TRIM_W-1:0]      win_trim;
    logic signed [MEAS_W:0] win_err;

    // Move a trim code by a step, clamping at both range ends.
    function automatic logic [TRIM_W-1:0] sat_move(
        input logic [TRIM_W-1:0] t,
        input logic [TRIM_W-1:0] s,
        input logic              up
    );
        logic [TRIM_W:0] sum;
        sum = {1'b0, t} + {1'b0, s};
        if (up) return sum[TRIM_W] ? {TRIM_W{1'b1}} : sum[TRIM_W-1:0];
        return (s > t) ? '0 : (t - s);
    endfunction

    // Edge acceptance and per-iteration decisions.
    always_comb begin
        fall_ok   = fall_i && (state_q == ST_WAIT_FALL) && !start_i;
        rise_ok   = rise_i && (state_q == ST_WAIT_RISE) && !start_i;
        step_half = step_q >> 1;
        bin_hit   = !too_high && !too_low;
        bin_last  = (step_half == '0);
        best_load = rise_ok && !nbr_q && !bin_hit && bin_last && nbr_en_i;
        best_upd  = rise_ok && nbr_q;
    end

    trim_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (fall_ok),
        .meas_o (meas)
    );

    trim_err_calc #(.MEAS_W(MEAS_W)) u_err (
        .exact_i    (nbr_en_i),
        .meas_i     (meas),
        .target_i   (target_i),
        .tol_i      (tol_i),
        .err_o      (err),
        .abs_o      (err_abs),
        .too_high_o (too_high),
        .too_low_o  (too_low)
    );

    trim_best_track #(.TRIM_W(TRIM_W), .MEAS_W(MEAS_W)) u_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (best_load),
        .upd_i      (best_upd),
        .trim_i     (trim_q),
        .err_i      (err),
        .abs_i      (err_abs),
        .win_trim_o (win_trim),
        .win_err_o  (win_err)
    );

    // Search sequencer: start, binary iterations, neighbour probes, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            trim_q   <= TRIM_MID;
            step_q   <= '0;
            dir_up_q <= 1'b0;
            nbr_q    <= 1'b0;
            nidx_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                state_q <= ST_WAIT_FALL;
                if (!(rep_mode_i && retry_i)) trim_q <= default_trim_i;
                step_q  <= STEP_INIT;
                nbr_q   <= 1'b0;
                nidx_q  <= 1'b0;
            end else if (rise_ok) begin
                if (!nbr_q) begin
                    if (bin_hit) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        err_q   <= err;
                    end else begin
                        trim_q   <= sat_move(trim_q, step_q, too_low);
                        dir_up_q <= too_low;
                        step_q   <= step_half;
                        if (bin_last && !nbr_en_i) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            err_q   <= err;
                        end else begin
                            state_q <= ST_WAIT_FALL;
                            if (bin_last) begin
                                nbr_q  <= 1'b1;
                                nidx_q <= 1'b0;
                            end
                        end
                    end
                end else if (!nidx_q) begin
                    trim_q  <= sat_move(trim_q, TRIM_W'(1), dir_up_q);
                    nidx_q  <= 1'b1;
                    state_q <= ST_WAIT_FALL;
                end else begin
                    trim_q  <= win_trim;
                    err_q   <= win_err;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
            end else if (fall_ok) begin
                state_q <= ST_WAIT_RISE;
            end
        end
    end

    assign trim_o     = trim_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign done_err_o = err_q;
endmodule

// File: rtl/osc_trim_search_chk.sv
// Protocol checker for osc_trim_search, attached by bind.
// Assumes the same synchronous active-low reset as the design.
module osc_trim_search_chk #(
    parameter int TRIM_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rep_mode_i,
    input logic              retry_i,
    input logic              rise_i,
    input logic [TRIM_W-1:0] default_trim_i,
    input logic [TRIM_W-1:0] trim_o,
    input logic              busy_o,
    input logic              done_o
);
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o); // R2
    AST_START_LOADS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !(rep_mode_i && retry_i)) |=> (trim_o == $past(default_trim_i))); // R2
    AST_RETRY_KEEPS_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && rep_mode_i && retry_i) |=> $stable(trim_o)); // R10
    AST_TRIM_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !(rise_i && busy_o)) |=> $stable(trim_o)); // R12
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R11
endmodule

bind osc_trim_search osc_trim_search_chk #(.TRIM_W(TRIM_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .rep_mode_i     (rep_mode_i),
    .retry_i        (retry_i),
    .rise_i         (rise_i),
    .default_trim_i (default_trim_i),
    .trim_o         (trim_o),
    .busy_o         (busy_o),
    .done_o         (done_o)
);

// File: tb/osc_trim_search_bench.sv
`timescale 1ns/1ps
// Directed bench: a line model turns the current trim into a low-period
// length; each task runs one scenario and checks its own results.
module osc_trim_search_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, rep_mode_i = 1'b0, retry_i = 1'b0, nbr_en_i = 1'b0;
    logic fall_i = 1'b0, rise_i = 1'b0;
    logic [8:0] target_i = '0, tol_i = '0;
    logic [7:0] default_trim_i = 8'd128;
    logic [7:0] trim_o;
    logic busy_o, done_o;
    logic signed [9:0] done_err_o;

    int n_checks = 0, n_fail = 0, const_len = 100;
    bit summary_done = 0;

    always #2 clk = ~clk;

    osc_trim_search u_osc_trim_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rep_mode_i(rep_mode_i),
        .retry_i(retry_i), .nbr_en_i(nbr_en_i), .fall_i(fall_i), .rise_i(rise_i),
        .target_i(target_i), .tol_i(tol_i), .default_trim_i(default_trim_i),
        .trim_o(trim_o), .busy_o(busy_o), .done_o(done_o), .done_err_o(done_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        end
        $finish;
    endtask

    // Line model: 0 = pseudo-monotone (odd codes jump), 1 = half slope, 2 = fixed.
    function automatic int line_len(input int model, input int t);
        if (model == 0) return (t % 2 == 1) ? t + 23 : t + 20;
        if (model == 1) return t / 2 + 40;
        return const_len;
    endfunction

    task automatic start_run(input bit nbr, input int tgt, input int tol, input int dflt,
                             input bit rep, input bit rty);
        @(negedge clk);
        nbr_en_i = nbr; target_i = 9'(tgt); tol_i = 9'(tol);
        default_trim_i = 8'(dflt); rep_mode_i = rep; retry_i = rty; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // One low period of len cycles; returns on the edge after the rise.
    task automatic low_period(input int len);
        fall_i = 1'b1;
        @(negedge clk);
        fall_i = 1'b0;
        repeat (len - 1) @(negedge clk);
        rise_i = 1'b1;
        @(negedge clk);
        rise_i = 1'b0;
    endtask

    task automatic run_sync(input int model, input int exp_n, input int exp_trim,
                            input int exp_err, input string req);
        int n = 0;
        bit got = 0;
        while (!got && n < 12) begin
            low_period(line_len(model, int'(trim_o)));
            n++;
            if (done_o) got = 1;
            else repeat (3) @(negedge clk);
        end
        check(got, {req, " done seen"}, int'(got), 1);
        check(n == exp_n, {req, " measurement count"}, n, exp_n);
        check(int'(trim_o) == exp_trim, {req, " final trim"}, int'(trim_o), exp_trim);
        check(int'(done_err_o) == exp_err, {req, " final error"}, int'(done_err_o), exp_err);
        @(negedge clk);
        check(!done_o && !busy_o, "R11 done one cycle, busy low", int'({done_o, busy_o}), 0);
    endtask

    task automatic t_reset();
        check(int'(trim_o) == 128, "R1 reset trim", int'(trim_o), 128);
        check(!busy_o && !done_o, "R1 reset flags", int'({busy_o, done_o}), 0);
        check(done_err_o == 0, "R1 reset error", int'(done_err_o), 0);
    endtask

    task automatic t_binary_tol();
        start_run(0, 100, 2, 128, 0, 0);
        check(busy_o, "R2 busy after start", int'(busy_o), 1);
        check(int'(trim_o) == 128, "R2 default loaded", int'(trim_o), 128);
        run_sync(1, 5, 120, 0, "R4 R5 half-slope search");
    endtask

    task automatic t_binary_variants();
        start_run(0, 151, 1, 128, 0, 0);
        run_sync(0, 6, 132, 1, "R5 stop inside tolerance");
        start_run(0, 151, 0, 128, 0, 0);
        run_sync(0, 7, 131, -1, "R6 step reaches zero");
    endtask

    task automatic t_neighbour();
        start_run(1, 151, 5, 128, 0, 0);
        run_sync(0, 9, 130, -1, "R7 R8 neighbour best of three");
        start_run(1, 100, 7, 128, 0, 0);
        run_sync(1, 5, 120, 0, "R7 exact match ends early");
    endtask

    task automatic t_long_count();
        const_len = 300;
        start_run(0, 300, 0, 77, 0, 0);
        run_sync(2, 1, 77, 0, "R3 ninth count bit");
        const_len = 600;
        start_run(0, 511, 0, 77, 0, 0);
        run_sync(2, 1, 77, 0, "R3 count holds at 511");
    endtask

    task automatic t_stray_strobes();
        start_run(0, 120, 0, 128, 0, 0);
        rise_i = 1'b1;
        @(negedge clk);
        rise_i = 1'b0;
        check(int'(trim_o) == 128 && busy_o, "R3 early rise ignored", int'(trim_o), 128);
        fall_i = 1'b1;
        @(negedge clk);
        fall_i = 1'b0;
        repeat (48) @(negedge clk);
        fall_i = 1'b1;
        @(negedge clk);
        fall_i = 1'b0;
        repeat (70) @(negedge clk);
        rise_i = 1'b1;
        @(negedge clk);
        rise_i = 1'b0;
        check(done_o, "R3 second fall ignored, done", int'(done_o), 1);
        check(int'(trim_o) == 128 && done_err_o == 0, "R3 count from first fall",
              int'(done_err_o), 0);
    endtask

    task automatic t_idle_strobes();
        int seen = 0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            low_period(20);
            if (done_o || busy_o) seen++;
        end
        check(seen == 0, "R12 idle strobes no done", seen, 0);
        check(int'(trim_o) == 128, "R12 idle trim kept", int'(trim_o), 128);
    endtask

    task automatic t_saturate();
        start_run(0, 400, 0, 200, 0, 0);
        run_sync(0, 7, 255, -122, "R9 saturate high");
        start_run(0, 5, 0, 10, 0, 0);
        run_sync(0, 7, 0, 15, "R9 saturate low");
    endtask

    task automatic t_retry();
        start_run(0, 100, 0, 128, 1, 1);
        check(int'(trim_o) == 0, "R10 retry keeps trim", int'(trim_o), 0);
        start_run(0, 100, 0, 128, 0, 1);
        check(int'(trim_o) == 128, "R10 plain start reloads", int'(trim_o), 128);
        start_run(0, 100, 0, 99, 1, 0);
        check(int'(trim_o) == 99, "R10 non-retry start reloads", int'(trim_o), 99);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_binary_tol();
        t_binary_variants();
        t_neighbour();
        t_long_count();
        t_stray_strobes();
        t_idle_strobes();
        t_saturate();
        t_retry();
        repeat (4) @(negedge clk);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        summary();
    end
endmodule